// File: doc/BRIEF.md
# Clock Gate Enable Controller

This block decides, cycle by cycle, whether one clock-gating cell should pass its clock. A small control register holds an ownership select, a software enable, two turn-off hysteresis bits and a read-only status bit. When software owns the gate, the gate follows the register's enable bit. When hardware owns it, the gate follows a request input from the consuming logic.

Turning the gate on always takes effect at the next clock edge. Turning it off can be held back by a short or a long hysteresis interval. A new request that arrives during that interval cancels the pending turn-off. The status bit repeats the gate state after a fixed settle time, so software can poll it to learn when a change has taken effect.

Two build-time options shape each gate instance. A gate can be marked as one that must never turn off under software ownership. A gate can also be built without software control, in which case the ownership select and enable bits cannot be written.

Top module: `clkgate_ctrl`

## Requirements
- R1: Register bit positions are: bit 0 ownership (1 = software owns), bit 1 software enable, bit 2 status (read-only), bit 3 hysteresis enable, bit 4 long-interval select. After reset every bit reads 0, and gate_en and gate_status are 0.
- R2: Under software ownership, gate_en follows the enable bit. A register write at edge E affects gate_en from edge E+1.
- R3: Under hardware ownership, gate_en follows hw_req, which is registered: a level sampled at edge E appears on gate_en after E.
- R4: gate_status equals the value gate_en had two edges earlier. A write to bit 2 has no effect.
- R5: A gate built with NO_DISABLE=1 stays on under software ownership while its enable bit is 0. The enable bit still reads back as written.
- R6: A gate built with SW_CAPABLE=0 ignores writes to bits 0 and 1, reads them as 0, and follows hw_req.
- R7: With hysteresis disabled, gate_en falls one edge after the request drops. With it enabled and bit 4 at 0, gate_en falls SHORT_DLY edges later than that.
- R8: With hysteresis enabled and bit 4 at 1, gate_en falls LONG_DLY edges later than without hysteresis.
- R9: Turn-on is never delayed. A request that returns during a pending turn-off keeps gate_en at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 5 | Register write data |
| reg_rdata | output | 5 | Register read data, status included |
| hw_req | input | 1 | Hardware enable request |
| gate_en | output | 1 | Enable to the clock-gating cell |
| gate_status | output | 1 | Settled gate state for polling |

## Verification
The bench builds three copies of the block, all with SHORT_DLY=3 and LONG_DLY=7. These delays are deliberately different from the defaults and from each other, so an off-by-one in either countdown, or the two intervals swapped, moves the falling edge of gate_en to a cycle the bench checks. One copy has NO_DISABLE=1 and another has SW_CAPABLE=0, so both build options are exercised against the same bus traffic as the ordinary copy. A re-request placed one cycle before the short countdown would expire checks that cancellation takes effect at the latest possible point.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  localparam int REG_W     = 5;
  localparam int FLD_SEL   = 0;
  localparam int FLD_EN    = 1;
  localparam int FLD_STAT  = 2;
  localparam int FLD_HEN   = 3;
  localparam int FLD_HLONG = 4;

  typedef struct packed {
    logic hlong;
    logic hen;
    logic en;
    logic sel;
  } gate_cfg_t;
endpackage

// File: rtl/clkgate_regs.sv
module clkgate_regs
  import clkgate_pkg::*;
#(
  parameter bit SW_CAPABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output gate_cfg_t        cfg
);
  logic hen_q, hlong_q;
  logic unused_stat;

  assign unused_stat = wdata[FLD_STAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      hen_q   <= 1'b0;
      hlong_q <= 1'b0;
    end else if (we) begin
      hen_q   <= wdata[FLD_HEN];
      hlong_q <= wdata[FLD_HLONG];
    end
  end

  generate
    if (SW_CAPABLE) begin : g_sw
      logic sel_q, en_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          sel_q <= 1'b0;
          en_q  <= 1'b0;
        end else if (we) begin
          sel_q <= wdata[FLD_SEL];
          en_q  <= wdata[FLD_EN];
        end
      end
      assign cfg.sel = sel_q;
      assign cfg.en  = en_q;

      // R2: a written enable bit is held in the register
      a_r2_en_capture: assert property (@(posedge clk) disable iff (rst)
        we |=> cfg.en == $past(wdata[FLD_EN]));
    end else begin : g_hw_only
      logic unused_sw;
      assign unused_sw = wdata[FLD_SEL] ^ wdata[FLD_EN];
      assign cfg.sel = 1'b0;
      assign cfg.en  = 1'b0;
    end
  endgenerate

  assign cfg.hen   = hen_q;
  assign cfg.hlong = hlong_q;

  // R7: hysteresis configuration follows the bus
  a_r7_hyst_capture: assert property (@(posedge clk) disable iff (rst)
    we |=> cfg.hen == $past(wdata[FLD_HEN]));
endmodule

// File: rtl/clkgate_hyst.sv
module clkgate_hyst #(
  parameter int SHORT_DLY = 4,
  parameter int LONG_DLY  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic want,
  input  logic hen,
  input  logic hlong,
  output logic gate_q
);
  localparam int CW = $clog2(LONG_DLY + 1);
  localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_DLY);
  localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_DLY);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit = hlong ? LONG_LIM : SHORT_LIM;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      cnt    <= '0;
    end else if (want) begin
      gate_q <= 1'b1;
      cnt    <= '0;
    end else if (gate_q) begin
      if (!hen || cnt >= limit) begin
        gate_q <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R9: turn-on is never held back
  a_r9_turn_on: assert property (@(posedge clk) disable iff (rst)
    want |=> gate_q);
  // R7: without hysteresis the gate drops one edge after the request
  a_r7_no_hyst: assert property (@(posedge clk) disable iff (rst)
    (gate_q && !want && !hen) |=> !gate_q);
  // R8: countdown never runs past the long interval
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LONG_LIM);
  // R9: a falling gate always follows an absent request
  a_r9_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_q) |-> !$past(want));
endmodule

// File: rtl/clkgate_settle.sv
module clkgate_settle #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe[0] <= din;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= 1'b0;
        else     pipe[i] <= pipe[i-1];
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
  import clkgate_pkg::*;
#(
  parameter int SHORT_DLY  = 4,
  parameter int LONG_DLY   = 16,
  parameter int SETTLE_CYC = 2,
  parameter bit NO_DISABLE = 1'b0,
  parameter bit SW_CAPABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             hw_req,
  output logic             gate_en,
  output logic             gate_status
);
  gate_cfg_t cfg;
  logic      want;

  clkgate_regs #(.SW_CAPABLE(SW_CAPABLE)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .wdata(reg_wdata), .cfg(cfg)
  );

  assign want = cfg.sel ? (cfg.en | NO_DISABLE) : hw_req;

  clkgate_hyst #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) u_hyst (
    .clk(clk), .rst(rst), .want(want), .hen(cfg.hen), .hlong(cfg.hlong),
    .gate_q(gate_en)
  );

  clkgate_settle #(.STAGES(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst), .din(gate_en), .dout(gate_status)
  );

  always_comb begin
    reg_rdata            = '0;
    reg_rdata[FLD_SEL]   = cfg.sel;
    reg_rdata[FLD_EN]    = cfg.en;
    reg_rdata[FLD_STAT]  = gate_status;
    reg_rdata[FLD_HEN]   = cfg.hen;
    reg_rdata[FLD_HLONG] = cfg.hlong;
  end

  // R1: reset clears gate and status
  a_r1_reset: assert property (@(posedge clk)
    $past(rst) |-> (!gate_en && !gate_status));

  generate
    if (SETTLE_CYC == 2) begin : g_a_settle
      // R4: status trails the gate by two edges
      a_r4_status_lag: assert property (@(posedge clk) disable iff (rst)
        gate_status == $past(gate_en, 2));
    end
    if (NO_DISABLE) begin : g_a_nd
      // R5: software-owned gate never turns off
      a_r5_no_disable: assert property (@(posedge clk) disable iff (rst)
        (cfg.sel && $past(cfg.sel)) |-> gate_en);
    end
  endgenerate
endmodule

// File: tb/clkgate_ctrl_bench.sv
module clkgate_ctrl_bench;
  localparam int SH = 3;
  localparam int LG = 7;
  localparam int NV = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic we = 1'b0;
  logic [4:0] wd = '0;
  logic hw = 1'b0;
  logic [4:0] rd, rd_nd, rd_ns;
  logic g, st, g_nd, st_nd, g_ns, st_ns;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clkgate_ctrl #(.SHORT_DLY(SH), .LONG_DLY(LG)) u_clkgate_ctrl (
    .clk(clk), .rst(rst), .reg_we(we), .reg_wdata(wd), .reg_rdata(rd),
    .hw_req(hw), .gate_en(g), .gate_status(st));
  clkgate_ctrl #(.SHORT_DLY(SH), .LONG_DLY(LG), .NO_DISABLE(1'b1)) u_nd (
    .clk(clk), .rst(rst), .reg_we(we), .reg_wdata(wd), .reg_rdata(rd_nd),
    .hw_req(hw), .gate_en(g_nd), .gate_status(st_nd));
  clkgate_ctrl #(.SHORT_DLY(SH), .LONG_DLY(LG), .SW_CAPABLE(1'b0)) u_ns (
    .clk(clk), .rst(rst), .reg_we(we), .reg_wdata(wd), .reg_rdata(rd_ns),
    .hw_req(hw), .gate_en(g_ns), .gate_status(st_ns));

  // {we, wdata[4:0], hw_req, expected gate_en, expected gate_status}
  localparam logic [8:0] VEC [NV] = '{
    9'b0_00000_1_1_0, 9'b0_00000_1_1_0, 9'b0_00000_1_1_1, 9'b0_00000_0_0_1,
    9'b0_00000_0_0_1, 9'b0_00000_0_0_0, 9'b1_00011_0_0_0, 9'b0_00000_0_1_0,
    9'b0_00000_0_1_0, 9'b0_00000_0_1_1, 9'b1_00001_1_1_1, 9'b0_00000_1_0_1,
    9'b0_00000_1_0_1, 9'b0_00000_1_0_0, 9'b1_01011_0_0_0, 9'b0_00000_0_1_0,
    9'b0_00000_0_1_0, 9'b0_00000_0_1_1, 9'b1_01001_0_1_1, 9'b0_00000_0_1_1,
    9'b0_00000_0_1_1, 9'b0_00000_0_1_1, 9'b0_00000_0_0_1, 9'b0_00000_0_0_1,
    9'b0_00000_0_0_0
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [4:0] d, input logic h);
    @(negedge clk);
    we = w; wd = d; hw = h;
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) step();
    chk("R1 reset rdata", rd, 0);
    chk("R1 reset gate", g, 0);
    chk("R1 reset status", st, 0);
    @(negedge clk); rst = 1'b0;
    drive(1'b1, 5'b00100, 1'b0); step();
    chk("R4 status write ignored", rd[2], 0);
    drive(1'b0, 5'b00000, 1'b0); step(); step();

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][8], VEC[i][7:3], VEC[i][2]);
      step();
      if (i < 6) begin
        chk($sformatf("R3 vec %0d gate", i), g, VEC[i][1]);
      end else if (i < 14) begin
        chk($sformatf("R2 vec %0d gate", i), g, VEC[i][1]);
      end else begin
        chk($sformatf("R7 vec %0d gate", i), g, VEC[i][1]);
      end
      chk($sformatf("R4 vec %0d status", i), st, VEC[i][0]);
    end

    // long hysteresis
    drive(1'b1, 5'b11011, 1'b0); step();
    chk("R1 readback", rd, 5'b11011);
    drive(1'b0, 5'b00000, 1'b0); step();
    chk("R9 turn-on with hysteresis", g, 1);
    step(); step();
    drive(1'b1, 5'b11001, 1'b0); step();
    drive(1'b0, 5'b00000, 1'b0);
    for (int k = 1; k <= LG; k++) begin
      step();
      chk($sformatf("R8 long hold %0d", k), g, 1);
    end
    step();
    chk("R8 long drop", g, 0);

    // cancel of a pending short turn-off
    drive(1'b1, 5'b01011, 1'b0); step();
    drive(1'b0, 5'b00000, 1'b0); step();
    drive(1'b1, 5'b01001, 1'b0); step();
    drive(1'b0, 5'b00000, 1'b0); step(); step();
    drive(1'b1, 5'b01011, 1'b0); step();
    drive(1'b0, 5'b00000, 1'b0);
    for (int k = 0; k < 8; k++) begin
      step();
      chk($sformatf("R9 cancel hold %0d", k), g, 1);
    end

    // build options
    drive(1'b1, 5'b00001, 1'b0); step();
    drive(1'b0, 5'b00000, 1'b0); step(); step();
    chk("R5 no-disable gate", g_nd, 1);
    chk("R5 no-disable enable readback", rd_nd[1:0], 2'b01);
    chk("R2 ordinary gate off", g, 0);
    chk("R6 select/enable ignored", rd_ns[1:0], 0);
    chk("R6 follows hw low", g_ns, 0);
    drive(1'b1, 5'b00011, 1'b1); step();
    drive(1'b0, 5'b00000, 1'b1); step();
    chk("R6 follows hw high", g_ns, 1);
    chk("R6 enable still ignored", rd_ns[1:0], 0);
    drive(1'b0, 5'b00000, 1'b0); step();
    chk("R6 follows hw drop", g_ns, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule